// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block is a small bank of control registers that sits on a simple peripheral bus. It claims a fixed 16 Kbyte window near the top of a 32-bit address map, and it drives its stored bits straight out as control lines for a peripheral. Software never writes a register directly. Each register instead has three word addresses. A write to the first sets the bits given as 1 in the data. A write to the second clears those bits. The third returns the current value when read. A single bit can therefore be changed with one store and no read-modify-write sequence.

The bus side is deliberately plain: one address, one write data word, a write strobe, a read strobe and a read data word. A write takes effect on the clock edge where the strobe is high. Read data is combinational while the read strobe is high, and it is zero at every other time. No request ever stalls, so there is no valid/ready back-pressure. Every access completes in the cycle it is presented.

Top module: `sc_alias_bank`

## Requirements
- R1: After a synchronous active-low reset, every register and every control output bit is 0.
- R2: Register i (0 to 3) owns the set alias at window byte offset 12*i. A write there drives to 1 every register bit whose write-data bit is 1, effective on the same clock edge.
- R3: The clear alias of register i is at window byte offset 12*i+4. A write there drives to 0 every register bit whose write-data bit is 1.
- R4: Register bits whose write-data bit is 0 keep their value on a set-alias or clear-alias write.
- R5: While the read strobe is high and the address is the read alias (window offset 12*i+8), read data equals register i.
- R6: A read of a set alias or a clear alias returns 0.
- R7: A write to a read alias changes no register.
- R8: The window-select output is high exactly when the address lies in [BASE, BASE+16384). The default BASE is 0xFFFE4000, which is in the top 3 Mbyte of the map. The output is combinational and does not depend on the strobes.
- R9: An access outside the window changes no register, and a read there returns 0.
- R10: Inside the window, word offsets at or above 12 (the fifth group onward) are unmapped. Writes there are ignored and reads return 0.
- R11: Address bits 1:0 are ignored. Any byte address within an alias word selects that alias.
- R12: With no write strobe, the control outputs hold their value. Read data is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data (bit mask for set/clear) |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading a read alias |
| win_sel | output | 1 | Address falls inside this block's window |
| ctrl_out | output | 128 | Register contents, register i on bits 32*i+31 to 32*i |

## Verification
The properties assume that the read and write strobes are never high in the same cycle. They also assume that the address and write data are stable across the clock edge at which a write strobe is sampled. The bench keeps to both conditions by driving every input on the falling edge and raising at most one strobe per access. It holds each strobe for exactly one rising edge. The sweeps walk every word offset of the mapped groups and the first unmapped ones. They also visit the addresses on both sides of each window boundary, so the properties meet every alias kind while their assumptions hold.

// File: rtl/sc_bank_pkg.sv
package sc_bank_pkg;
  localparam int          DEF_AW     = 32;
  localparam int          DEF_DW     = 32;
  localparam int          DEF_NREGS  = 4;
  localparam int          DEF_WIN_LG = 14;
  localparam logic [31:0] DEF_BASE   = 32'hFFFE_4000;

  // Position of a word inside a three-word alias group.
  typedef enum logic [1:0] {
    SLOT_SET  = 2'd0,
    SLOT_CLR  = 2'd1,
    SLOT_RD   = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  function automatic int clog2_min1(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/sc_win_decode.sv
module sc_win_decode #(
  parameter int              AW     = sc_bank_pkg::DEF_AW,
  parameter int              WIN_LG = sc_bank_pkg::DEF_WIN_LG,
  parameter logic [AW-1:0]   BASE   = AW'(sc_bank_pkg::DEF_BASE),
  localparam int             WW     = WIN_LG - 2
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [WW-1:0] word
);
  // The base is window aligned, so a tag compare on the upper bits suffices.
  localparam logic [AW-WIN_LG-1:0] TAG = BASE[AW-1:WIN_LG];

  logic unused_lane;
  assign unused_lane = ^addr[1:0];

  assign hit  = (addr[AW-1:WIN_LG] == TAG);
  assign word = addr[WIN_LG-1:2];
endmodule

// File: rtl/sc_alias_decode.sv
module sc_alias_decode
  import sc_bank_pkg::*;
#(
  parameter int  WW     = DEF_WIN_LG - 2,
  parameter int  NREGS  = DEF_NREGS,
  localparam int IW     = clog2_min1(NREGS)
) (
  input  logic          hit,
  input  logic [WW-1:0] word,
  output slot_e         slot,
  output logic [IW-1:0] idx
);
  // Each register owns three consecutive words: set, clear, read.
  always_comb begin
    slot = SLOT_NONE;
    idx  = '0;
    if (hit) begin
      for (int i = 0; i < NREGS; i++) begin
        if (word == WW'(3 * i)) begin
          slot = SLOT_SET;
          idx  = IW'(i);
        end else if (word == WW'(3 * i + 1)) begin
          slot = SLOT_CLR;
          idx  = IW'(i);
        end else if (word == WW'(3 * i + 2)) begin
          slot = SLOT_RD;
          idx  = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/sc_bit_reg.sv
module sc_bit_reg #(
  parameter int DW = sc_bank_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] q
);
  logic [DW-1:0] nxt;

  // Clear wins over set on a shared bit.
  always_comb begin
    nxt = q;
    if (set_en) nxt = nxt | mask;
    if (clr_en) nxt = nxt & ~mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/sc_alias_bank.sv
module sc_alias_bank
  import sc_bank_pkg::*;
#(
  parameter int            AW     = DEF_AW,
  parameter int            DW     = DEF_DW,
  parameter int            NREGS  = DEF_NREGS,
  parameter int            WIN_LG = DEF_WIN_LG,
  parameter logic [AW-1:0] BASE   = AW'(DEF_BASE),
  localparam int           WW     = WIN_LG - 2,
  localparam int           IW     = clog2_min1(NREGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [DW-1:0]       bus_rdata,
  output logic                win_sel,
  output logic [NREGS*DW-1:0] ctrl_out
);
  logic [WW-1:0] word;
  slot_e         slot;
  logic [IW-1:0] idx;
  logic [DW-1:0] q [NREGS];

  sc_win_decode #(.AW(AW), .WIN_LG(WIN_LG), .BASE(BASE)) win_i (
    .addr (bus_addr),
    .hit  (win_sel),
    .word (word)
  );

  sc_alias_decode #(.WW(WW), .NREGS(NREGS)) dec_i (
    .hit  (win_sel),
    .word (word),
    .slot (slot),
    .idx  (idx)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic mine;
    assign mine = (idx == IW'(g));

    sc_bit_reg #(.DW(DW)) reg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (bus_wr && mine && (slot == SLOT_SET)),
      .clr_en (bus_wr && mine && (slot == SLOT_CLR)),
      .mask   (bus_wdata),
      .q      (q[g])
    );

    assign ctrl_out[g*DW +: DW] = q[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && (slot == SLOT_RD)) begin
      for (int i = 0; i < NREGS; i++) begin
        if (idx == IW'(i)) bus_rdata = q[i];
      end
    end
  end
endmodule

// File: rtl/sc_alias_bank_chk.sv
module sc_alias_bank_chk
  import sc_bank_pkg::*;
#(
  parameter int            AW     = DEF_AW,
  parameter int            DW     = DEF_DW,
  parameter int            NREGS  = DEF_NREGS,
  parameter logic [AW-1:0] BASE   = AW'(DEF_BASE)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [DW-1:0]       bus_rdata,
  input logic                win_sel,
  input logic [NREGS*DW-1:0] ctrl_out
);
  // R12: registers only move on a write strobe.
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(ctrl_out));

  // R12: no read strobe, no read data.
  a_r12_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

  // R9: outside the window nothing moves and nothing is returned.
  a_r9_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !win_sel) |=> $stable(ctrl_out));

  a_r9_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !win_sel) |-> bus_rdata == '0);

  for (genvar r = 0; r < NREGS; r++) begin : g_chk
    localparam logic [AW-1:0] A_SET = BASE + AW'(12 * r);
    localparam logic [AW-1:0] A_CLR = BASE + AW'(12 * r + 4);
    localparam logic [AW-1:0] A_RD  = BASE + AW'(12 * r + 8);

    // R2
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && {bus_addr[AW-1:2], 2'b00} == A_SET)
      |=> (ctrl_out[r*DW +: DW] & $past(bus_wdata)) == $past(bus_wdata));

    // R3
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && {bus_addr[AW-1:2], 2'b00} == A_CLR)
      |=> (ctrl_out[r*DW +: DW] & $past(bus_wdata)) == '0);

    // R4
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ({bus_addr[AW-1:2], 2'b00} == A_SET ||
                  {bus_addr[AW-1:2], 2'b00} == A_CLR))
      |=> ((ctrl_out[r*DW +: DW] ^ $past(ctrl_out[r*DW +: DW]))
           & ~$past(bus_wdata)) == '0);

    // R7
    a_r7_read_alias_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && {bus_addr[AW-1:2], 2'b00} == A_RD) |=> $stable(ctrl_out));

    // R5
    a_r5_read_value: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && {bus_addr[AW-1:2], 2'b00} == A_RD)
      |-> bus_rdata == ctrl_out[r*DW +: DW]);

    // R6
    a_r6_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ({bus_addr[AW-1:2], 2'b00} == A_SET ||
                  {bus_addr[AW-1:2], 2'b00} == A_CLR)) |-> bus_rdata == '0);
  end
endmodule

bind sc_alias_bank sc_alias_bank_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .win_sel   (win_sel),
  .ctrl_out  (ctrl_out)
);

// File: tb/sc_alias_bank_tb_top.sv
module sc_alias_bank_tb_top;
  localparam logic [31:0] BASE = 32'hFFFE_4000;
  localparam logic [31:0] WIN  = 32'd16384;
  localparam int          NR   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          win_sel;
  logic [127:0]  ctrl_out;

  logic [31:0]   model [NR];
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  sc_alias_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .win_sel(win_sel), .ctrl_out(ctrl_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int r = 0; r < NR; r++) chk(req, ctrl_out[r*32 +: 32], model[r]);
  endtask

  // Drive at the falling edge; the write lands on the next rising edge,
  // so outputs are settled by the following falling edge.
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic s);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; s = win_sel;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int n);
    logic [31:0] x;
    x = 32'h9E37_79B9 * 32'(n + 1);
    return x ^ (x >> 13);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        s;
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");
    chk("R12 rdata idle", bus_rdata, 32'h0);

    // R2 / R3 / R4 / R5 sweep over each register with varied masks
    for (int r = 0; r < NR; r++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] ps, pc;
        ps = pat(r * 16 + k);
        pc = pat(r * 16 + k + 100);
        wr(BASE + 32'(12 * r), ps);
        model[r] = model[r] | ps;
        chk_all("R2 set");
        rd(BASE + 32'(12 * r + 8), d, s);
        chk("R5 read alias", d, model[r]);
        wr(BASE + 32'(12 * r + 4), pc);
        model[r] = model[r] & ~pc;
        chk_all("R3 clear");
      end
      wr(BASE + 32'(12 * r), 32'h0);
      chk_all("R4 zero set");
      wr(BASE + 32'(12 * r + 4), 32'h0);
      chk_all("R4 zero clear");
    end

    // Walk every word offset of the mapped groups plus unmapped ones
    for (int w = 0; w < 20; w++) begin
      logic [31:0] e;
      rd(BASE + 32'(4 * w), d, s);
      if (w < 3 * NR && (w % 3) == 2) e = model[w / 3];
      else                             e = 32'h0;
      chk((w < 3 * NR) ? "R6 R5 offset read" : "R10 unmapped read", d, e);
      chk("R8 sel inside", {31'h0, s}, 32'h1);
    end

    // R7: writes to read aliases are ignored
    for (int r = 0; r < NR; r++) begin
      wr(BASE + 32'(12 * r + 8), 32'hFFFF_FFFF);
      chk_all("R7 read alias write");
    end

    // R10: writes to unmapped window words are ignored
    for (int w = 3 * NR; w < 3 * NR + 6; w++) begin
      wr(BASE + 32'(4 * w), 32'hFFFF_FFFF);
      chk_all("R10 unmapped write");
    end
    wr(BASE + WIN - 4, 32'hFFFF_FFFF);
    chk_all("R10 top word write");

    // R8 / R9: window edges and far addresses
    rd(BASE - 4, d, s);
    chk("R8 below base sel", {31'h0, s}, 32'h0);
    chk("R9 below base read", d, 32'h0);
    rd(BASE + WIN - 4, d, s);
    chk("R8 last word sel", {31'h0, s}, 32'h1);
    rd(BASE + WIN, d, s);
    chk("R8 past end sel", {31'h0, s}, 32'h0);
    chk("R9 past end read", d, 32'h0);
    rd(32'h0000_0008, d, s);
    chk("R8 low sel", {31'h0, s}, 32'h0);
    for (int r = 0; r < NR; r++) begin
      wr(BASE - WIN + 32'(12 * r), 32'hFFFF_FFFF);
      wr(BASE + WIN + 32'(12 * r), 32'hFFFF_FFFF);
      wr(32'(12 * r), 32'hFFFF_FFFF);
      chk_all("R9 outside write");
    end

    // R11: byte-lane bits are ignored
    for (int r = 0; r < NR; r++) begin
      wr(BASE + 32'(12 * r + 3), 32'h8000_0001);
      model[r] = model[r] | 32'h8000_0001;
      chk_all("R11 unaligned set");
      wr(BASE + 32'(12 * r + 4 + 2), 32'h0000_0001);
      model[r] = model[r] & ~32'h0000_0001;
      chk_all("R11 unaligned clear");
      rd(BASE + 32'(12 * r + 8 + 1), d, s);
      chk("R11 unaligned read", d, model[r]);
    end

    // R12: hold over idle cycles
    repeat (10) @(negedge clk);
    chk_all("R12 hold");

    // R1: reset clears a non-zero bank
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < NR; r++) model[r] = '0;
    chk_all("R1 re-reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule